// File: doc/BRIEF.md
# Register Address Space Router

This block sits on an internal register bus between one requester and a set of register banks. Each bank owns a contiguous window of the 16-bit register address space, fixed at elaboration by a base and a span. Every request is offered to all banks at once. Only the bank whose window contains the address sees the read or write strobe, and that bank receives the address already rebased so that its first register is at zero. Write data goes to every bank regardless of the address.

On the way back the block does not steer a multiplexer by address. It folds all bank responses into one. Data and the valid pulse are ORed, and ready is ANDed. A bank that is not answering must therefore present zero data, valid low and ready high. A bank selected by a wrong address cannot hide behind a mux, and adding a bank costs one OR/AND stage.

A parameter selects whether the downstream request is registered (one cycle of latency, the default) or passed through combinationally. The response path is always combinational.

Top module: `regrt_router`

## Requirements
- R1: The request vector is 50 bits wide: write strobe at bit 0, read strobe at bit 1, write data at bits 33:2 and address at bits 49:34. Each downstream request slice i sits at bits [50*i+49 : 50*i] and uses the same layout.
- R2: Bank i claims address A only when BASE_i <= A < BASE_i + SPAN_i. Only a claimed bank receives the read or write strobe, on the clock edge after the upstream strobe when the request stage is enabled.
- R3: The address BASE_i + SPAN_i is not claimed by bank i. It goes to the bank whose window starts there, if one does, and otherwise to no bank.
- R4: The strobes of every bank that does not claim the address stay low. Write data reaches every bank unchanged, whether or not that bank is claimed.
- R5: Every bank receives the address minus its own base, modulo 2^16.
- R6: The response vector is 34 bits wide: ready at bit 0, valid at bit 1 and data at bits 33:2. Upstream data is the bitwise OR of all bank data, upstream valid is the OR of all valids, and upstream ready is the AND of all readies, all in the same cycle.
- R7: A bank presenting zero data, valid low and ready high leaves the merged response unchanged. With every bank idle, the upstream response is ready high, valid low and data zero.
- R8: A request to an address that no bank claims raises no downstream strobe. With idle banks, the upstream response stays ready high and valid low.
- R9: While reset is asserted, every downstream request slice is all zero, even if the upstream side presents a strobe.
- R10: A one-cycle upstream strobe produces a one-cycle downstream strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional request stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 50 | Upstream request vector |
| up_rsp | output | 34 | Merged upstream response vector |
| dn_req | output | 50*N_SPACES | One rebased, strobe-gated request slice per bank |
| dn_rsp | input | 34*N_SPACES | One response slice per bank |

## Verification
The request path and the response path are independent, so a new strobe can be routed in the same cycle that another bank's read data is merged upstream. The bench provokes this by issuing a read to one bank while a second bank drives a valid response. It judges the merged response at once and the routed strobe one edge later, and expects neither to disturb the other. The window edges are walked at the first address, the last address and the first address past each window, including gaps between windows and the top of the address space.

// File: rtl/regrt_pkg.sv
package regrt_pkg;
   localparam int unsigned RA_W = 16;
   localparam int unsigned RD_W = 32;

   // Field order is behaviour: write strobe lands at bit 0, address on top.
   typedef struct packed {
      logic [RA_W-1:0] addr;
      logic [RD_W-1:0] data;
      logic            rd;
      logic            wr;
   } rreq_t;

   // Ready at bit 0, valid at bit 1, data above.
   typedef struct packed {
      logic [RD_W-1:0] data;
      logic            vld;
      logic            rdy;
   } rrsp_t;

   localparam int unsigned RREQ_W = $bits(rreq_t);
   localparam int unsigned RRSP_W = $bits(rrsp_t);

   localparam rreq_t REQ_IDLE = '0;
   localparam rrsp_t RSP_IDLE = '{data: '0, vld: 1'b0, rdy: 1'b1};
endpackage

// File: rtl/regrt_space_port.sv
module regrt_space_port
   import regrt_pkg::*;
#(
   parameter logic [RA_W-1:0] BASE = '0,
   parameter int unsigned     SPAN = 1
) (
   input  rreq_t up,
   output rreq_t dn
);
   localparam logic [RA_W:0] LO    = {1'b0, BASE};
   localparam logic [RA_W:0] LIMIT = LO + (RA_W+1)'(SPAN);

   generate
      if (SPAN == 0) begin : g_bad_span
         $error("regrt_space_port: zero span");
      end
      if ((64'(BASE) + 64'(SPAN)) > (64'd1 << RA_W)) begin : g_bad_top
         $error("regrt_space_port: window runs past the address space");
      end
   endgenerate

   logic [RA_W:0] a_ext;
   logic          hit;

   assign a_ext = {1'b0, up.addr};
   assign hit   = (a_ext >= LO) && (a_ext < LIMIT);

   always_comb begin
      dn.addr = up.addr - BASE;
      dn.data = up.data;
      dn.rd   = up.rd & hit;
      dn.wr   = up.wr & hit;
   end
endmodule

// File: rtl/regrt_req_stage.sv
module regrt_req_stage
   import regrt_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rreq_t d,
   output rreq_t q
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= REQ_IDLE;
            else        q <= d;
         end
      end else begin : g_thru
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/regrt_rsp_merge.sv
module regrt_rsp_merge
   import regrt_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  rrsp_t rsp [N],
   output rrsp_t merged
);
   rrsp_t acc [N+1];

   assign acc[0] = RSP_IDLE;

   generate
      for (genvar i = 0; i < N; i++) begin : g_fold
         assign acc[i+1].data = acc[i].data | rsp[i].data;
         assign acc[i+1].vld  = acc[i].vld  | rsp[i].vld;
         assign acc[i+1].rdy  = acc[i].rdy  & rsp[i].rdy;
      end
   endgenerate

   assign merged = acc[N];
endmodule

// File: rtl/regrt_router.sv
module regrt_router
   import regrt_pkg::*;
#(
   parameter int unsigned                  N_SPACES   = 4,
   parameter logic [N_SPACES*RA_W-1:0]     SPACE_BASE = {16'h0100, 16'h0040, 16'h0010, 16'h0000},
   parameter logic [N_SPACES*32-1:0]       SPACE_SPAN = {32'd128, 32'd64, 32'd32, 32'd16},
   parameter bit                           REQ_STAGE  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [RREQ_W-1:0]            up_req,
   output logic [RRSP_W-1:0]            up_rsp,
   output logic [N_SPACES*RREQ_W-1:0]   dn_req,
   input  logic [N_SPACES*RRSP_W-1:0]   dn_rsp
);
   generate
      if (N_SPACES < 1) begin : g_bad_n
         $error("regrt_router: need at least one space");
      end
   endgenerate

   rreq_t up_s;
   rrsp_t rsp_s [N_SPACES];
   rrsp_t merged;

   assign up_s = rreq_t'(up_req);

   generate
      for (genvar i = 0; i < N_SPACES; i++) begin : g_space
         localparam logic [RA_W-1:0] B = SPACE_BASE[i*RA_W +: RA_W];
         localparam int unsigned     S = SPACE_SPAN[i*32 +: 32];

         // windows must be disjoint
         for (genvar j = i + 1; j < N_SPACES; j++) begin : g_olap
            localparam int unsigned BJ = SPACE_BASE[j*RA_W +: RA_W];
            localparam int unsigned SJ = SPACE_SPAN[j*32 +: 32];
            if ((int'(B) < BJ + SJ) && (BJ < int'(B) + S)) begin : g_bad
               $error("regrt_router: overlapping windows");
            end
         end

         rreq_t comb_q;
         rreq_t stage_q;

         regrt_space_port #(.BASE(B), .SPAN(S)) u_port (
            .up (up_s),
            .dn (comb_q)
         );

         regrt_req_stage #(.REGISTERED(REQ_STAGE)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (comb_q),
            .q     (stage_q)
         );

         assign dn_req[i*RREQ_W +: RREQ_W] = stage_q;
         assign rsp_s[i] = rrsp_t'(dn_rsp[i*RRSP_W +: RRSP_W]);
      end
   endgenerate

   regrt_rsp_merge #(.N(N_SPACES)) u_merge (
      .rsp    (rsp_s),
      .merged (merged)
   );

   assign up_rsp = merged;
endmodule

// File: rtl/regrt_chk.sv
module regrt_chk
   import regrt_pkg::*;
#(
   parameter int unsigned              N_SPACES   = 4,
   parameter logic [N_SPACES*RA_W-1:0] SPACE_BASE = '0,
   parameter logic [N_SPACES*32-1:0]   SPACE_SPAN = '0,
   parameter bit                       REQ_STAGE  = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [RREQ_W-1:0]          up_req,
   input logic [RRSP_W-1:0]          up_rsp,
   input logic [N_SPACES*RREQ_W-1:0] dn_req,
   input logic [N_SPACES*RRSP_W-1:0] dn_rsp
);
   rreq_t up_s;
   rreq_t seen;
   logic  primed;

   assign up_s = rreq_t'(up_req);

   generate
      if (REQ_STAGE) begin : g_delay
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen   <= '0;
               primed <= 1'b0;
            end else begin
               seen   <= up_s;
               primed <= 1'b1;
            end
         end
      end else begin : g_now
         assign seen   = up_s;
         assign primed = 1'b1;
      end
   endgenerate

   logic all_idle;
   always_comb begin
      all_idle = 1'b1;
      for (int k = 0; k < N_SPACES; k++) begin
         if (dn_rsp[k*RRSP_W +: RRSP_W] != RRSP_W'(RSP_IDLE)) all_idle = 1'b0;
      end
   end

   // R7
   idle_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> (up_rsp == RRSP_W'(1)));

   generate
      for (genvar i = 0; i < N_SPACES; i++) begin : g_sp
         localparam logic [RA_W:0] LO = {1'b0, SPACE_BASE[i*RA_W +: RA_W]};
         localparam logic [RA_W:0] HI = LO + (RA_W+1)'(SPACE_SPAN[i*32 +: 32]);
         rreq_t d_i;
         logic  in_i;
         assign d_i  = rreq_t'(dn_req[i*RREQ_W +: RREQ_W]);
         assign in_i = ({1'b0, seen.addr} >= LO) && ({1'b0, seen.addr} < HI);

         // R2
         claim_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (d_i.rd == (seen.rd && in_i)));
         // R2
         claim_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (d_i.wr == (seen.wr && in_i)));
         // R4
         data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (d_i.data == seen.data));
         // R5
         rebase_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (d_i.addr == RA_W'(seen.addr - LO[RA_W-1:0])));
         // R10
         pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (d_i.rd && !up_s.rd) |=> !d_i.rd);
      end
   endgenerate
endmodule

bind regrt_router regrt_chk #(
   .N_SPACES   (N_SPACES),
   .SPACE_BASE (SPACE_BASE),
   .SPACE_SPAN (SPACE_SPAN),
   .REQ_STAGE  (REQ_STAGE)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .up_req (up_req),
   .up_rsp (up_rsp),
   .dn_req (dn_req),
   .dn_rsp (dn_rsp)
);

// File: tb/sim_regrt_router.sv
module sim_regrt_router;
   localparam int NS = 4;
   localparam int BASES [NS] = '{0, 16, 64, 256};

   typedef struct packed {
      logic [15:0] a;
      logic        rd;
      logic        wr;
      logic [3:0]  hit;
   } vec_t;

   // hit bit i set means bank i must claim the address
   localparam vec_t VEC [12] = '{
      '{16'h0000, 1'b1, 1'b0, 4'b0001},
      '{16'h000F, 1'b0, 1'b1, 4'b0001},
      '{16'h0010, 1'b1, 1'b0, 4'b0010},
      '{16'h002F, 1'b0, 1'b1, 4'b0010},
      '{16'h0030, 1'b1, 1'b0, 4'b0000},
      '{16'h0040, 1'b0, 1'b1, 4'b0100},
      '{16'h007F, 1'b1, 1'b0, 4'b0100},
      '{16'h0080, 1'b0, 1'b1, 4'b0000},
      '{16'h0100, 1'b1, 1'b0, 4'b1000},
      '{16'h017F, 1'b0, 1'b1, 4'b1000},
      '{16'h0180, 1'b1, 1'b0, 4'b0000},
      '{16'hFFFF, 1'b0, 1'b1, 4'b0000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [49:0]       up_req = '0;
   logic [33:0]       up_rsp;
   logic [NS*50-1:0]  dn_req;
   logic [NS*34-1:0]  dn_rsp;
   int                n_run = 0;
   int                n_fail = 0;
   bit                done = 1'b0;

   always #4 clk = ~clk;

   regrt_router u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_req (up_req),
      .up_rsp (up_rsp),
      .dn_req (dn_req),
      .dn_rsp (dn_rsp)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [33:0] idle_rsp();
      return {32'h0, 1'b0, 1'b1};
   endfunction

   task automatic all_idle();
      for (int i = 0; i < NS; i++) dn_rsp[i*34 +: 34] = idle_rsp();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      all_idle();
      // R9: strobe offered during reset must not appear
      up_req = {16'h0000, 32'hDEAD_BEEF, 1'b1, 1'b1};
      repeat (3) @(negedge clk);
      chk("R9 reset slices", 64'(dn_req), 64'h0);
      up_req = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 all idle response
      #1 chk("R7 idle merge", 64'(up_rsp), 64'h1);

      // R1 R2 R3 R4 R5 R10 table walk
      for (int k = 0; k < 12; k++) begin
         logic [31:0] wd;
         wd = 32'hC0DE_0000 + 32'(k);
         @(negedge clk);
         up_req = {VEC[k].a, wd, VEC[k].rd, VEC[k].wr};
         if (k == 0) #1 chk("R2 no strobe before edge", 64'(dn_req[1:0]), 64'h0);
         @(negedge clk);
         for (int i = 0; i < NS; i++) begin
            logic [49:0] s;
            logic [15:0] ea;
            s  = dn_req[i*50 +: 50];
            ea = VEC[k].a - 16'(BASES[i]);
            chk($sformatf("R2 R3 rd v%0d s%0d", k, i), 64'(s[1]), 64'(VEC[k].rd & VEC[k].hit[i]));
            chk($sformatf("R4 wr v%0d s%0d", k, i), 64'(s[0]), 64'(VEC[k].wr & VEC[k].hit[i]));
            chk($sformatf("R4 data v%0d s%0d", k, i), 64'(s[33:2]), 64'(wd));
            chk($sformatf("R5 R1 addr v%0d s%0d", k, i), 64'(s[49:34]), 64'(ea));
         end
         up_req[1:0] = 2'b00;
         @(negedge clk);
         for (int i = 0; i < NS; i++)
            chk($sformatf("R10 pulse v%0d s%0d", k, i), 64'(dn_req[i*50 +: 2]), 64'h0);
      end

      // R8 unclaimed address with idle banks
      @(negedge clk);
      up_req = {16'h00C0, 32'h1111_2222, 1'b1, 1'b0};
      @(negedge clk);
      for (int i = 0; i < NS; i++)
         chk($sformatf("R8 no strobe s%0d", i), 64'(dn_req[i*50 +: 2]), 64'h0);
      chk("R8 rsp", 64'(up_rsp), 64'h1);
      up_req[1:0] = 2'b00;

      // R6 merge cases
      all_idle();
      dn_rsp[2*34 +: 34] = {32'hA5A5_0000, 1'b1, 1'b1};
      #1 chk("R7 single responder", 64'(up_rsp), 64'({32'hA5A5_0000, 1'b1, 1'b1}));
      all_idle();
      dn_rsp[1*34 +: 34] = {32'h0, 1'b0, 1'b0};
      #1 chk("R6 ready and", 64'(up_rsp), 64'({32'h0, 1'b0, 1'b0}));
      all_idle();
      dn_rsp[0*34 +: 34] = {32'h0000_00F0, 1'b1, 1'b1};
      dn_rsp[3*34 +: 34] = {32'h0F00_0000, 1'b0, 1'b1};
      #1 chk("R6 data or", 64'(up_rsp), 64'({32'h0F00_00F0, 1'b1, 1'b1}));

      // same cycle: new read to bank 2 while bank 3 answers
      @(negedge clk);
      all_idle();
      dn_rsp[3*34 +: 34] = {32'h0000_1234, 1'b1, 1'b1};
      up_req = {16'h0050, 32'h0, 1'b1, 1'b0};
      #1 chk("R6 rsp during request", 64'(up_rsp), 64'({32'h0000_1234, 1'b1, 1'b1}));
      @(negedge clk);
      all_idle();
      up_req[1:0] = 2'b00;
      chk("R2 rd routed during rsp", 64'(dn_req[2*50 +: 2]), 64'h2);
      chk("R5 rebased during rsp", 64'(dn_req[2*50+34 +: 16]), 64'h10);
      chk("R4 other bank quiet", 64'(dn_req[3*50 +: 2]), 64'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule